// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block takes frames that a bus engine has already accepted and places each one into a bank of receive mailboxes. Every mailbox carries four settings: an enable bit, a direction bit, an identifier word with its acceptance mask, and an overwrite-protection bit. An arriving frame goes to the highest-numbered mailbox that is enabled, set to receive, and whose filter accepts the identifier. The frame's identifier, RTR bit, length and payload are written into that mailbox. The mailbox's pending bit is then set, and the interrupt output goes high.

When the chosen mailbox still holds an unread message, the protection bit decides what happens. A protected mailbox is skipped and the next lower eligible mailbox is tried. An unprotected mailbox is overwritten, and its lost bit and a global lost flag are set. Host software can drop mailboxes out of allocation at any time by clearing their enable bits. This lets the upper mailboxes act as a main bank that is drained in order, while the lower mailboxes absorb overflow.

Top module: `rxmb_alloc`

## Requirements
- R1: A frame with `frm_valid` high is stored in the highest-numbered mailbox that is eligible. A mailbox is eligible when its enable bit is 1, its direction bit is 1 (receive), its filter matches, and it is not both protected and pending.
- R2: Identifier words use bit 31 for the extended format and bit 30 for mask enable. An extended identifier occupies bits 28:0 and a standard identifier occupies bits 28:18. Without mask enable, the filter compares bit 31 and the identifier bits exactly; a standard frame compares only bits 28:18.
- R3: With mask enable set, the filter ignores every compared bit whose mask bit is 1. An all-ones mask therefore accepts any identifier.
- R4: Storing a frame sets the mailbox's bit in `rx_pend` one clock later. Writing `clr_we` with a 1 in `clr_mask` clears both the pending bit and the lost bit of that mailbox. `irq_flags[15]` and `irq` are high while any bit is pending.
- R5: A mailbox that is protected and pending is never written. The frame goes to the next lower eligible mailbox instead.
- R6: Storing into an unprotected pending mailbox overwrites it and sets its `rx_lost` bit and the sticky flag `irq_flags[11]`. A pulse on `lost_clr` clears that flag.
- R7: A configuration write takes effect for the next frame. A mailbox with enable 0 or direction 0 is never chosen.
- R8: A frame that no eligible mailbox accepts is dropped, and `rx_pend`, `rx_lost` and `irq_flags` stay unchanged.
- R9: The stored length is the frame DLC clamped to 8. Payload bytes at or above the stored length read as zero; byte k is `rd_data[8k+7:8k]`.
- R10: After reset all settings, pending bits, lost bits and flags are zero.
- R11: The read port returns the selected mailbox's received identifier in the R2 word format, with bit 30 zero, together with its RTR bit, length and payload.
- R12: `cfg_sel` selects the target of a configuration write: 0 writes the enable vector, 1 the direction vector, 2 the protection vector (each taken from `cfg_data[N-1:0]`), 3 the identifier word of mailbox `cfg_idx`, and 4 its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target (R12) |
| cfg_idx | input | $clog2(NMBOX) | Mailbox for identifier/mask writes |
| cfg_data | input | 32 | Configuration write data |
| frm_valid | input | 1 | Accepted frame strobe |
| frm_ide | input | 1 | Frame uses extended identifier |
| frm_rtr | input | 1 | Remote request frame |
| frm_id | input | 29 | Identifier, standard in bits 10:0 |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload, byte 0 in bits 7:0 |
| clr_we | input | 1 | Pending/lost clear strobe |
| clr_mask | input | NMBOX | Write-1 clear mask |
| lost_clr | input | 1 | Clears the global lost flag |
| rd_idx | input | $clog2(NMBOX) | Mailbox read select |
| rd_word | output | 32 | Received identifier word |
| rd_dlc | output | 4 | Stored length |
| rd_rtr | output | 1 | Stored RTR bit |
| rd_data | output | 64 | Stored payload |
| rx_pend | output | NMBOX | Pending bits |
| rx_lost | output | NMBOX | Lost bits |
| irq_flags | output | 16 | Bit 15 any pending, bit 11 lost flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong choice in the priority pick or the filter shows up one clock after the frame strobe: the pending bit appears in the wrong position of `rx_pend`, or no bit appears at all. A protection bit that is ignored, or a stale pending vector, shows up as a changed `rx_lost` bit and a raised `irq_flags[11]` in that same cycle. A wrong length clamp or byte mask shows up at the read port as soon as the mailbox is selected. The bench fills the main bank so that overflow falls into the filtered lower mailboxes, and each frame's pending, lost and read-port results are compared with a model the bench keeps itself.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

  localparam int ID_W     = 29;
  localparam int IDE_BIT  = 31;
  localparam int AME_BIT  = 30;
  localparam int STD_LSB  = 18;
  localparam int MAX_LEN  = 8;

  typedef enum logic [2:0] {
    CFG_EN   = 3'd0,
    CFG_DIR  = 3'd1,
    CFG_OVP  = 3'd2,
    CFG_ID   = 3'd3,
    CFG_MASK = 3'd4
  } cfg_sel_e;

  // Build the identifier word of an incoming frame.
  function automatic logic [31:0] frame_word(input logic ide, input logic [ID_W-1:0] id);
    logic [31:0] w;
    w = '0;
    if (ide) begin
      w[IDE_BIT]    = 1'b1;
      w[ID_W-1:0]   = id;
    end else begin
      w[STD_LSB +: 11] = id[10:0];
    end
    return w;
  endfunction

  // Filter decision of one mailbox for one frame word.
  function automatic logic id_match(input logic [31:0] fw, input logic [31:0] cfg,
                                    input logic [31:0] mask);
    logic [31:0] care;
    care = 32'h9FFF_FFFF;
    if (!fw[IDE_BIT]) care[STD_LSB-1:0] = '0;
    if (cfg[AME_BIT]) care = care & ~mask;
    return ((fw ^ cfg) & care) == 32'h0;
  endfunction

  function automatic logic [3:0] clamp_len(input logic [3:0] dlc);
    return (dlc > 4'(MAX_LEN)) ? 4'(MAX_LEN) : dlc;
  endfunction

  // Zero the payload bytes at or above the stored length.
  function automatic logic [63:0] keep_bytes(input logic [63:0] d, input logic [3:0] len);
    logic [63:0] r;
    r = d;
    for (int b = 0; b < MAX_LEN; b++) begin
      if (4'(b) >= len) r[b*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxmb_filter.sv
module rxmb_filter
  import rxmb_pkg::*;
#(
  parameter int NMBOX = 8
) (
  input  logic [31:0]            fw,
  input  logic [NMBOX-1:0][31:0] cfg_id,
  input  logic [NMBOX-1:0][31:0] cfg_mask,
  input  logic [NMBOX-1:0]       en,
  input  logic [NMBOX-1:0]       dir,
  input  logic [NMBOX-1:0]       ovp,
  input  logic [NMBOX-1:0]       pend,
  output logic [NMBOX-1:0]       eligible
);

  for (genvar gi = 0; gi < NMBOX; gi++) begin : g_mb
    logic hit_id;
    logic blocked;
    assign hit_id       = id_match(fw, cfg_id[gi], cfg_mask[gi]);
    assign blocked      = ovp[gi] & pend[gi];
    assign eligible[gi] = en[gi] & dir[gi] & hit_id & ~blocked;
  end

endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
  parameter int NMBOX = 8
) (
  input  logic [NMBOX-1:0] eligible,
  output logic [NMBOX-1:0] grant,
  output logic             hit
);

  always_comb begin
    grant = '0;
    for (int i = 0; i < NMBOX; i++) begin
      if (eligible[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign hit = |grant;

  // R1
  always_comb begin
    one_grant_chk: assert ($onehot0(grant));
  end

endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
  import rxmb_pkg::*;
#(
  parameter int NMBOX = 8,
  localparam int IDX_W = (NMBOX > 1) ? $clog2(NMBOX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMBOX-1:0]  wr_vec,
  input  logic [31:0]       wr_word,
  input  logic              wr_rtr,
  input  logic [3:0]        wr_len,
  input  logic [63:0]       wr_data,
  input  logic              clr_we,
  input  logic [NMBOX-1:0]  clr_mask,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_word,
  output logic [3:0]        rd_len,
  output logic              rd_rtr,
  output logic [63:0]       rd_data,
  output logic [NMBOX-1:0]  pend,
  output logic [NMBOX-1:0]  lost,
  output logic              lost_evt
);

  logic [NMBOX-1:0][31:0] mb_word;
  logic [NMBOX-1:0][3:0]  mb_len;
  logic [NMBOX-1:0]       mb_rtr;
  logic [NMBOX-1:0][63:0] mb_data;
  logic [NMBOX-1:0]       clr_vec;
  logic [NMBOX-1:0]       ovw_vec;

  assign clr_vec  = clr_we ? clr_mask : '0;
  assign ovw_vec  = wr_vec & pend;
  assign lost_evt = |ovw_vec;

  for (genvar gi = 0; gi < NMBOX; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mb_word[gi] <= '0;
        mb_len[gi]  <= '0;
        mb_rtr[gi]  <= 1'b0;
        mb_data[gi] <= '0;
      end else if (wr_vec[gi]) begin
        mb_word[gi] <= wr_word;
        mb_len[gi]  <= wr_len;
        mb_rtr[gi]  <= wr_rtr;
        mb_data[gi] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      lost <= '0;
    end else begin
      pend <= (pend & ~clr_vec) | wr_vec;
      lost <= (lost & ~clr_vec) | ovw_vec;
    end
  end

  assign rd_word = mb_word[rd_idx];
  assign rd_len  = mb_len[rd_idx];
  assign rd_rtr  = mb_rtr[rd_idx];
  assign rd_data = mb_data[rd_idx];

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_vec) |=> ((pend & $past(wr_vec)) == $past(wr_vec)));

  // R6
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(wr_vec & pend)) |=> (|(lost & $past(wr_vec))));

endmodule

// File: rtl/rxmb_alloc.sv
module rxmb_alloc
  import rxmb_pkg::*;
#(
  parameter int NMBOX = 8,
  localparam int IDX_W = (NMBOX > 1) ? $clog2(NMBOX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_data,
  input  logic              frm_valid,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  input  logic [28:0]       frm_id,
  input  logic [3:0]        frm_dlc,
  input  logic [63:0]       frm_data,
  input  logic              clr_we,
  input  logic [NMBOX-1:0]  clr_mask,
  input  logic              lost_clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_word,
  output logic [3:0]        rd_dlc,
  output logic              rd_rtr,
  output logic [63:0]       rd_data,
  output logic [NMBOX-1:0]  rx_pend,
  output logic [NMBOX-1:0]  rx_lost,
  output logic [15:0]       irq_flags,
  output logic              irq
);

  logic [NMBOX-1:0]       en_q, dir_q, ovp_q;
  logic [NMBOX-1:0][31:0] id_q, mask_q;
  logic [NMBOX-1:0]       eligible, grant, wr_vec;
  logic                   hit, lost_evt, lost_q;
  logic [31:0]            fw;
  logic [3:0]             len;

  // Settings registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      dir_q  <= '0;
      ovp_q  <= '0;
      id_q   <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        CFG_EN:   en_q  <= cfg_data[NMBOX-1:0];
        CFG_DIR:  dir_q <= cfg_data[NMBOX-1:0];
        CFG_OVP:  ovp_q <= cfg_data[NMBOX-1:0];
        CFG_ID:   id_q[cfg_idx]   <= cfg_data;
        CFG_MASK: mask_q[cfg_idx] <= cfg_data;
        default: ;
      endcase
    end
  end

  assign fw  = frame_word(frm_ide, frm_id);
  assign len = clamp_len(frm_dlc);

  rxmb_filter #(.NMBOX(NMBOX)) u_filter (
    .fw       (fw),
    .cfg_id   (id_q),
    .cfg_mask (mask_q),
    .en       (en_q),
    .dir      (dir_q),
    .ovp      (ovp_q),
    .pend     (rx_pend),
    .eligible (eligible)
  );

  rxmb_pick #(.NMBOX(NMBOX)) u_pick (
    .eligible (eligible),
    .grant    (grant),
    .hit      (hit)
  );

  assign wr_vec = frm_valid ? grant : '0;

  rxmb_store #(.NMBOX(NMBOX)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vec   (wr_vec),
    .wr_word  (fw),
    .wr_rtr   (frm_rtr),
    .wr_len   (len),
    .wr_data  (keep_bytes(frm_data, len)),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .rd_idx   (rd_idx),
    .rd_word  (rd_word),
    .rd_len   (rd_dlc),
    .rd_rtr   (rd_rtr),
    .rd_data  (rd_data),
    .pend     (rx_pend),
    .lost     (rx_lost),
    .lost_evt (lost_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lost_q <= 1'b0;
    else if (lost_evt) lost_q <= 1'b1;
    else if (lost_clr) lost_q <= 1'b0;
  end

  always_comb begin
    irq_flags     = '0;
    irq_flags[15] = |rx_pend;
    irq_flags[11] = lost_q;
  end
  assign irq = irq_flags[15] | irq_flags[11];

  // R1
  top_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && hit) |-> ((eligible & ~(grant - 1'b1) & ~grant) == '0));

  // R5
  ovp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> ((grant & ovp_q & rx_pend) == '0));

  // R6
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(lost_evt));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !hit && !clr_we) |=> ($stable(rx_pend) && $stable(rx_lost)));

endmodule

// File: tb/rxmb_alloc_bench.sv
`timescale 1ns/1ps
module rxmb_alloc_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [28:0] frm_id = '0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        clr_we = 1'b0;
  logic [N-1:0] clr_mask = '0;
  logic        lost_clr = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_word;
  logic [3:0]  rd_dlc;
  logic        rd_rtr;
  logic [63:0] rd_data;
  logic [N-1:0] rx_pend, rx_lost;
  logic [15:0] irq_flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_pend = '0, m_lost = '0;
  logic         m_flag = 1'b0;

  always #10 clk = ~clk;

  rxmb_alloc #(.NMBOX(N)) u_rxmb_alloc (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_idx, .cfg_data,
    .frm_valid, .frm_ide, .frm_rtr, .frm_id, .frm_dlc, .frm_data,
    .clr_we, .clr_mask, .lost_clr, .rd_idx,
    .rd_word, .rd_dlc, .rd_rtr, .rd_data,
    .rx_pend, .rx_lost, .irq_flags, .irq
  );

  typedef struct packed {
    logic        ide;
    logic        rtr;
    logic [28:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [3:0]  slot;   // 4'hF: dropped
    logic        lost;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 29'h055,     4'd8,  64'h0807060504030201, 4'd7,  1'b0},
    '{1'b0, 1'b0, 29'h100,     4'd3,  64'hFFFFFFFFFFFFFFFF, 4'd6,  1'b0},
    '{1'b1, 1'b0, 29'h1ABCDE5, 4'd15, 64'h1122334455667788, 4'd5,  1'b0},
    '{1'b0, 1'b1, 29'h7FF,     4'd0,  64'hAAAAAAAAAAAAAAAA, 4'd4,  1'b0},
    '{1'b0, 1'b0, 29'h123,     4'd5,  64'h0102030405060708, 4'd3,  1'b0},
    '{1'b0, 1'b0, 29'h124,     4'd5,  64'h0,                4'hF,  1'b0},
    '{1'b1, 1'b0, 29'h1ABCDE3, 4'd2,  64'hCAFEBABEDEADBEEF, 4'd2,  1'b0},
    '{1'b0, 1'b0, 29'h123,     4'd6,  64'h5555666677778888, 4'd3,  1'b1},
    '{1'b1, 1'b0, 29'h1ABCDF3, 4'd4,  64'h0,                4'hF,  1'b0}
  };

  function automatic logic [31:0] exp_word(logic ide, logic [28:0] id);
    return ide ? (32'h8000_0000 | {3'b0, id}) : ({21'b0, id[10:0]} << 18);
  endfunction

  function automatic logic [63:0] exp_data(logic [63:0] d, logic [3:0] dlc);
    int n;
    n = (dlc > 4'd8) ? 8 : int'(dlc);
    if (n == 8) return d;
    return d & ((64'd1 << (8 * n)) - 64'd1);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [2:0] sel, logic [2:0] idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(logic ide, logic rtr, logic [28:0] id, logic [3:0] dlc, logic [63:0] d);
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id; frm_dlc = dlc; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic model_store(int slot);
    if (m_pend[slot]) begin
      m_lost[slot] = 1'b1;
      m_flag = 1'b1;
    end
    m_pend[slot] = 1'b1;
  endtask

  task automatic chk_state(string req);
    chk(req, 64'(rx_pend), 64'(m_pend));
    chk(req, 64'(rx_lost), 64'(m_lost));
    chk(req, 64'(irq_flags), {48'b0, |m_pend, 3'b0, m_flag, 11'b0});
  endtask

  task automatic clear(logic [N-1:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0;
    m_pend = m_pend & ~m;
    m_lost = m_lost & ~m;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", 64'(rx_pend), 64'h0);
    chk("R10", 64'(rx_lost), 64'h0);
    chk("R10", {48'b0, irq_flags}, 64'h0);
    chk("R10", 64'(irq), 64'h0);
    rst_n = 1'b1;
    // R7, R10: settings are zero, so a frame is dropped
    send(1'b0, 1'b0, 29'h055, 4'd1, 64'h1);
    chk("R10", 64'(rx_pend), 64'h0);

    // R12: configure main bank 7..4 and filtered buffer mailboxes 3, 2
    for (int i = 4; i < 8; i++) begin
      cfg(3'd3, 3'(i), 32'h4000_0000);
      cfg(3'd4, 3'(i), 32'hFFFF_FFFF);
    end
    cfg(3'd3, 3'd3, 32'(11'h123) << 18);
    cfg(3'd4, 3'd3, 32'h0);
    cfg(3'd3, 3'd2, 32'hC000_0000 | 32'h1ABCDE0);
    cfg(3'd4, 3'd2, 32'h0000_000F);
    cfg(3'd3, 3'd1, 32'h4000_0000);
    cfg(3'd4, 3'd1, 32'hFFFF_FFFF);
    cfg(3'd0, 3'd0, 32'h0000_00FC);
    cfg(3'd1, 3'd0, 32'h0000_00FC);
    cfg(3'd2, 3'd0, 32'h0000_00F0);

    // R1 R2 R3 R5 R6 R8 R9 R11: vector walk
    foreach (VECS[k]) begin
      send(VECS[k].ide, VECS[k].rtr, VECS[k].id, VECS[k].dlc, VECS[k].data);
      if (VECS[k].slot != 4'hF) model_store(int'(VECS[k].slot));
      chk_state("R1/R5/R6/R8 state");
      if (VECS[k].slot != 4'hF) begin
        chk("R6 lost", 64'(rx_lost[VECS[k].slot[2:0]]), 64'(VECS[k].lost));
        rd_idx = VECS[k].slot[2:0];
        #1;
        chk("R11 word", 64'(rd_word), 64'(exp_word(VECS[k].ide, VECS[k].id)));
        chk("R11 rtr", 64'(rd_rtr), 64'(VECS[k].rtr));
        chk("R9 dlc", 64'(rd_dlc), (VECS[k].dlc > 4'd8) ? 64'd8 : 64'(VECS[k].dlc));
        chk("R9 data", rd_data, exp_data(VECS[k].data, VECS[k].dlc));
      end
    end
    chk("R3 R5 bank", 64'(rx_pend), 64'hFC);

    // R4: write-1 clear of pending and lost
    clear(8'h88);
    chk_state("R4 clear");
    chk("R6 flag kept", 64'(irq_flags[11]), 64'h1);
    @(negedge clk); lost_clr = 1'b1;
    @(negedge clk); lost_clr = 1'b0;
    m_flag = 1'b0;
    chk("R6 lost_clr", 64'(irq_flags[11]), 64'h0);
    clear(8'hFF);
    chk_state("R4 all clear");
    chk("R4 irq low", 64'(irq), 64'h0);

    // R7: disabled mailbox 7 is skipped at once
    cfg(3'd0, 3'd0, 32'h0000_007C);
    send(1'b0, 1'b0, 29'h001, 4'd1, 64'h0);
    model_store(6);
    chk_state("R7 enable");
    // R7: direction 0 on mailbox 7 keeps it out
    cfg(3'd0, 3'd0, 32'h0000_00FC);
    cfg(3'd1, 3'd0, 32'h0000_007C);
    send(1'b0, 1'b0, 29'h002, 4'd1, 64'h0);
    model_store(5);
    chk_state("R7 direction");
    // R1: restored direction makes 7 the top choice again
    cfg(3'd1, 3'd0, 32'h0000_00FC);
    send(1'b0, 1'b0, 29'h003, 4'd1, 64'h0);
    model_store(7);
    chk_state("R1 restore");
    chk("R4 irq high", 64'(irq), 64'h1);

    // R2: standard frame must not hit an extended filter (mailbox 2 only)
    cfg(3'd0, 3'd0, 32'h0000_0004);
    send(1'b0, 1'b0, 29'h0E0, 4'd1, 64'h0);
    chk_state("R2 ide mismatch");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule